// File: doc/BRIEF.md
# Remote Bitbang JTAG Command Decoder

This block turns a stream of single-byte ASCII commands into JTAG pin activity. Each byte arrives on a valid/ready input channel. A digit writes TCK, TMS and TDI together. Four lower-case letters move the TAP reset line. An upper-case `R` samples TDO and returns one ASCII byte on a valid/ready output channel. An upper-case `Q` latches a quit flag, and from then on the decoder takes no more input until reset.

A one-cycle advance pulse tells the surrounding system when a command should let time move forward by one step. Pin writes and reset releases produce the pulse. Reset assertions, samples, quit and unknown bytes do not.

The reply path holds one byte. A sample command waits while that byte is still unaccepted. Other commands keep flowing while it waits. Reset is synchronous and active high.

Top module: `jbb_cmd_decoder`

## Requirements
- R1: While `rst` is high and in the cycle after it, TCK, TMS, TDI and TRST_n are low, `quit_o` and `rsp_valid` are low, and `cmd_ready` is high.
- R2: An accepted byte 0x30..0x37 (`'0'`..`'7'`) sets the pins in the following cycle: value bit 2 goes to TCK, bit 1 to TMS and bit 0 to TDI.
- R3: An accepted 0x72 or 0x73 (`'r'`, `'s'`) drives TRST_n high from the next cycle. An accepted 0x74 or 0x75 (`'t'`, `'u'`) drives it low.
- R4: An accepted 0x52 (`'R'`) puts 0x31 (`'1'`) on the reply channel in the next cycle if `tdo_i` was high at acceptance, and 0x30 (`'0'`) otherwise. `rsp_data` is held stable while `rsp_valid` is high and `rsp_ready` is low.
- R5: `step_o` is high for exactly the cycle after a digit or an `'r'`/`'s'` is accepted. It stays low after `'R'`, `'t'`, `'u'`, `'Q'` and ignored bytes.
- R6: An accepted 0x51 (`'Q'`) raises `quit_o` in the next cycle. While `quit_o` is high, `cmd_ready` is low, and later bytes change no pin until reset.
- R7: Any other byte is accepted and has no effect on the pins, TRST_n, `step_o` or the reply channel.
- R8: While a reply is pending and `rsp_ready` is low, an offered `'R'` sees `cmd_ready` low. Non-sample commands are still accepted.
- R9: A reply slot that is emptied in a cycle can take a new sample in that same cycle, so that `rsp_valid` stays high with the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Decoder takes the offered byte this cycle |
| cmd_data | input | 8 | ASCII command byte |
| rsp_valid | output | 1 | Reply byte available |
| rsp_ready | input | 1 | Consumer takes the reply byte |
| rsp_data | output | 8 | ASCII `'0'` or `'1'` reply |
| tdo_i | input | 1 | JTAG data from the TAP |
| tck_o | output | 1 | JTAG clock |
| tms_o | output | 1 | JTAG mode select |
| tdi_o | output | 1 | JTAG data to the TAP |
| trst_n_o | output | 1 | TAP reset, active low |
| step_o | output | 1 | One-cycle advance pulse |
| quit_o | output | 1 | Sticky quit flag |

## Verification
The hardest situation to reach is a second sample that meets a reply the consumer is still refusing. The bench has to show three things here: `cmd_ready` falls only for `'R'`, the pending byte stays put, and the queued sample slips in on the very edge the old byte leaves.

To reach it, the bench first drops `rsp_ready` and issues one sample, which leaves a byte waiting. It then sends a digit, which must still get through. Next it offers `'R'` with TDO flipped and holds it for several cycles. Finally it raises `rsp_ready` and checks the back-to-back handover against the scoreboard's queue of expected replies.

// File: rtl/jbb_pkg.sv
package jbb_pkg;

    localparam int CHAR_W = 8;
    localparam int PIN_N  = 3;

    localparam logic [CHAR_W-1:0] CH_DIGIT_LO = 8'h30;
    localparam logic [CHAR_W-1:0] CH_DIGIT_HI = 8'h37;
    localparam logic [CHAR_W-1:0] CH_REL_A    = 8'h72;
    localparam logic [CHAR_W-1:0] CH_REL_B    = 8'h73;
    localparam logic [CHAR_W-1:0] CH_HOLD_A   = 8'h74;
    localparam logic [CHAR_W-1:0] CH_HOLD_B   = 8'h75;
    localparam logic [CHAR_W-1:0] CH_SAMPLE   = 8'h52;
    localparam logic [CHAR_W-1:0] CH_QUIT     = 8'h51;
    localparam logic [CHAR_W-1:0] CH_ONE      = 8'h31;
    localparam logic [CHAR_W-1:0] CH_ZERO     = 8'h30;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PINS,
        OP_TRST_REL,
        OP_TRST_SET,
        OP_SAMPLE,
        OP_QUIT
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [PIN_N-1:0] pins;   // [2]=TCK [1]=TMS [0]=TDI
    } cmd_t;

    function automatic cmd_t classify(input logic [CHAR_W-1:0] ch);
        cmd_t c;
        c.op   = OP_NONE;
        c.pins = ch[PIN_N-1:0];
        if (ch >= CH_DIGIT_LO && ch <= CH_DIGIT_HI)
            c.op = OP_PINS;
        else if (ch == CH_REL_A || ch == CH_REL_B)
            c.op = OP_TRST_REL;
        else if (ch == CH_HOLD_A || ch == CH_HOLD_B)
            c.op = OP_TRST_SET;
        else if (ch == CH_SAMPLE)
            c.op = OP_SAMPLE;
        else if (ch == CH_QUIT)
            c.op = OP_QUIT;
        return c;
    endfunction

    function automatic logic advances(input op_e op);
        return (op == OP_PINS) || (op == OP_TRST_REL);
    endfunction

endpackage

// File: rtl/jbb_classify.sv
module jbb_classify
    import jbb_pkg::*;
(
    input  logic [CHAR_W-1:0] ch,
    output cmd_t              cmd
);
    always_comb cmd = classify(ch);
endmodule

// File: rtl/jbb_pin_drive.sv
module jbb_pin_drive
    import jbb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  cmd_t             cmd,
    output logic [PIN_N-1:0] pins,
    output logic             trst_n,
    output logic             step
);
    logic wr_pins;
    assign wr_pins = fire && (cmd.op == OP_PINS);

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                pins[i] <= 1'b0;
            else if (wr_pins)
                pins[i] <= cmd.pins[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trst_n <= 1'b0;
            step   <= 1'b0;
        end else begin
            step <= fire && advances(cmd.op);
            if (fire && cmd.op == OP_TRST_REL)
                trst_n <= 1'b1;
            else if (fire && cmd.op == OP_TRST_SET)
                trst_n <= 1'b0;
        end
    end
endmodule

// File: rtl/jbb_reply_slot.sv
module jbb_reply_slot
    import jbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              tdo,
    input  logic              ready,
    output logic              valid,
    output logic [CHAR_W-1:0] data,
    output logic              free
);
    assign free = !valid || ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= CH_ZERO;
        end else if (load) begin
            valid <= 1'b1;
            data  <= tdo ? CH_ONE : CH_ZERO;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/jbb_cmd_decoder.sv
module jbb_cmd_decoder
    import jbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [CHAR_W-1:0] cmd_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [CHAR_W-1:0] rsp_data,
    input  logic              tdo_i,
    output logic              tck_o,
    output logic              tms_o,
    output logic              tdi_o,
    output logic              trst_n_o,
    output logic              step_o,
    output logic              quit_o
);
    cmd_t             cmd;
    logic             fire;
    logic             slot_free;
    logic             quit_q;
    logic [PIN_N-1:0] pins;

    jbb_classify u_cls (.ch(cmd_data), .cmd(cmd));

    assign cmd_ready = !quit_q && ((cmd.op != OP_SAMPLE) || slot_free);
    assign fire      = cmd_valid && cmd_ready;

    jbb_pin_drive u_pins (
        .clk(clk), .rst(rst), .fire(fire), .cmd(cmd),
        .pins(pins), .trst_n(trst_n_o), .step(step_o)
    );

    jbb_reply_slot u_rsp (
        .clk(clk), .rst(rst),
        .load(fire && cmd.op == OP_SAMPLE),
        .tdo(tdo_i), .ready(rsp_ready),
        .valid(rsp_valid), .data(rsp_data), .free(slot_free)
    );

    always_ff @(posedge clk) begin
        if (rst)
            quit_q <= 1'b0;
        else if (fire && cmd.op == OP_QUIT)
            quit_q <= 1'b1;
    end

    assign tck_o  = pins[2];
    assign tms_o  = pins[1];
    assign tdi_o  = pins[0];
    assign quit_o = quit_q;
endmodule

// File: rtl/jbb_cmd_decoder_chk.sv
module jbb_cmd_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [7:0] cmd_data,
    input logic       rsp_valid,
    input logic       rsp_ready,
    input logic [7:0] rsp_data,
    input logic       tdo_i,
    input logic       tck_o,
    input logic       tms_o,
    input logic       tdi_o,
    input logic       trst_n_o,
    input logic       step_o,
    input logic       quit_o
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!tck_o && !tms_o && !tdi_o && !trst_n_o && !quit_o && !rsp_valid && !step_o));

    a_r2_pins_follow_digit: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_data >= 8'h30 && cmd_data <= 8'h37) |=>
        (tck_o == $past(cmd_data[2]) && tms_o == $past(cmd_data[1]) && tdi_o == $past(cmd_data[0])));

    a_r3_trst_release: assert property (@(posedge clk) disable iff (rst)
        (acc && (cmd_data == 8'h72 || cmd_data == 8'h73)) |=> trst_n_o);

    a_r3_trst_assert: assert property (@(posedge clk) disable iff (rst)
        (acc && (cmd_data == 8'h74 || cmd_data == 8'h75)) |=> !trst_n_o);

    a_r4_reply_value: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_data == 8'h52) |=>
        (rsp_valid && rsp_data == ($past(tdo_i) ? 8'h31 : 8'h30)));

    a_r4_reply_hold: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    a_r5_step_cause: assert property (@(posedge clk) disable iff (rst)
        step_o |-> $past(acc && ((cmd_data >= 8'h30 && cmd_data <= 8'h37) ||
                                 cmd_data == 8'h72 || cmd_data == 8'h73)));

    a_r6_quit_blocks: assert property (@(posedge clk) disable iff (rst)
        quit_o |-> !cmd_ready);

    a_r6_quit_sticky: assert property (@(posedge clk) disable iff (rst)
        quit_o |=> quit_o);

    a_r8_sample_stall: assert property (@(posedge clk) disable iff (rst)
        (cmd_data == 8'h52 && rsp_valid && !rsp_ready) |-> !cmd_ready);
endmodule

bind jbb_cmd_decoder jbb_cmd_decoder_chk chk_i (.*);

// File: tb/jbb_cmd_decoder_tb.sv
module jbb_cmd_decoder_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [7:0] cmd_data = 8'h00;
    logic       rsp_valid;
    logic       rsp_ready = 1'b1;
    logic [7:0] rsp_data;
    logic       tdo_i = 1'b0;
    logic       tck_o, tms_o, tdi_o, trst_n_o, step_o, quit_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    jbb_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .tdo_i(tdo_i), .tck_o(tck_o), .tms_o(tms_o),
        .tdi_o(tdi_o), .trst_n_o(trst_n_o), .step_o(step_o), .quit_o(quit_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: offer one byte, wait for acceptance, record expected reply
    task automatic send_cmd(input logic [7:0] c);
        logic took;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_data  = c;
        forever begin
            #1 took = cmd_ready;
            @(posedge clk);
            if (took) break;
            @(negedge clk);
        end
        if (c == 8'h52) exp_q.push_back(tdo_i ? 8'h31 : 8'h30);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_data  = 8'h00;
    endtask

    // monitor: pop and compare every reply handed over
    always @(negedge clk) begin
        #2;
        if (!rst && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected reply", {24'h0, rsp_data}, 32'hff);
            end else begin
                chk("R4 reply byte", {24'h0, rsp_data}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    task automatic chk_pins(input string req, input logic [2:0] p, input logic tr);
        chk(req, {29'h0, tck_o, tms_o, tdi_o}, {29'h0, p});
        chk(req, {31'h0, trst_n_o}, {31'h0, tr});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_pins("R1 pins in reset", 3'b000, 1'b0);
        chk("R1 quit", {31'h0, quit_o}, 0);
        chk("R1 rsp_valid", {31'h0, rsp_valid}, 0);
        chk("R1 cmd_ready", {31'h0, cmd_ready}, 1);
        rst = 1'b0;
        @(negedge clk);
        chk_pins("R1 pins after reset", 3'b000, 1'b0);

        // R3 release, R5 step
        send_cmd(8'h73);
        chk("R3 s releases", {31'h0, trst_n_o}, 1);
        chk("R5 step after s", {31'h0, step_o}, 1);
        @(negedge clk);
        chk("R5 step one cycle", {31'h0, step_o}, 0);
        send_cmd(8'h74);
        chk("R3 t asserts", {31'h0, trst_n_o}, 0);
        chk("R5 no step after t", {31'h0, step_o}, 0);
        send_cmd(8'h72);
        chk("R3 r releases", {31'h0, trst_n_o}, 1);
        send_cmd(8'h75);
        chk("R3 u asserts", {31'h0, trst_n_o}, 0);
        send_cmd(8'h72);

        // R2 all digits
        for (int d = 0; d < 8; d++) begin
            send_cmd(8'h30 + 8'(d));
            chk_pins("R2 digit pins", 3'(d), 1'b1);
            chk("R5 step after digit", {31'h0, step_o}, 1);
        end
        send_cmd(8'h35);

        // R7 ignored bytes
        send_cmd(8'h38);
        chk_pins("R7 '8' ignored", 3'b101, 1'b1);
        chk("R7 no step", {31'h0, step_o}, 0);
        send_cmd(8'h78);
        chk_pins("R7 'x' ignored", 3'b101, 1'b1);
        send_cmd(8'h53);
        chk("R7 'S' no reply", {31'h0, rsp_valid}, 0);
        chk("R7 'S' no step", {31'h0, step_o}, 0);

        // R4 samples with ready consumer
        tdo_i = 1'b1;
        send_cmd(8'h52);
        chk("R4 reply valid", {31'h0, rsp_valid}, 1);
        chk("R5 no step after R", {31'h0, step_o}, 0);
        tdo_i = 1'b0;
        send_cmd(8'h52);
        @(negedge clk);
        @(negedge clk);

        // R8 / R9 stall and back-to-back handover
        rsp_ready = 1'b0;
        tdo_i = 1'b1;
        send_cmd(8'h52);
        send_cmd(8'h32);
        chk_pins("R8 digit passes while pending", 3'b010, 1'b1);
        tdo_i = 1'b0;
        fork
            send_cmd(8'h52);
            begin
                repeat (3) begin
                    @(negedge clk);
                    #1;
                    chk("R8 R stalled", {31'h0, cmd_ready}, 0);
                    chk("R4 held byte", {24'h0, rsp_data}, 32'h31);
                end
                @(negedge clk);
                rsp_ready = 1'b1;
                @(negedge clk);
                #2;
                chk("R9 new reply valid", {31'h0, rsp_valid}, 1);
                chk("R9 new reply byte", {24'h0, rsp_data}, 32'h30);
            end
        join
        @(negedge clk);
        @(negedge clk);
        chk("R4 queue drained", exp_q.size(), 0);

        // R6 quit
        send_cmd(8'h51);
        chk("R6 quit set", {31'h0, quit_o}, 1);
        chk("R6 no step", {31'h0, step_o}, 0);
        cmd_valid = 1'b1;
        cmd_data  = 8'h37;
        repeat (3) begin
            @(negedge clk);
            #1;
            chk("R6 ready low", {31'h0, cmd_ready}, 0);
        end
        cmd_data = 8'h74;
        @(negedge clk);
        @(negedge clk);
        chk_pins("R6 pins frozen", 3'b010, 1'b1);
        cmd_valid = 1'b0;

        // R1 reset again
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk_pins("R1 reset clears", 3'b000, 1'b0);
        chk("R1 quit cleared", {31'h0, quit_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready again", {31'h0, cmd_ready}, 1);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule